// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier (MSD First, GF(2^163))

This block computes the product of two elements of GF(2^163) in polynomial basis, reduced modulo x^163 + x^7 + x^6 + x^3 + 1. The multiplicand A is latched once. The multiplier B is consumed one digit of D bits per clock, starting from its most significant digit. Inside each clock the digit's bits are handled from the top bit down by a chain of D combinational steps. Each step doubles the running value modulo the field polynomial, then XORs in A when the current bit of B is set. The running value therefore never grows beyond 163 bits, and no final reduction cycle is needed.

A controller with three states drives the datapath. In IDLE the block waits. A start pulse moves it to RUN: the operands are loaded, the accumulator is cleared, and one digit is processed per cycle. After the last digit the controller enters DONE for exactly one cycle and raises `done`. From DONE it returns to IDLE, or goes straight back to RUN if `start` is high. A start arriving while in RUN is ignored. The digit size D is a parameter; 4 and 48 are the intended settings. When 163 is not a multiple of D, B is padded with zeros above bit 162 and the padded top digit is processed first.

Top module: `gfm_msd_mul`

## Requirements
- R1: When `done` is high, `product` equals A·B reduced modulo x^163+x^7+x^6+x^3+1 (bit i is the coefficient of x^i), for any operands including zero, one and all-ones.
- R2: The result is correct both for D = 4, where B is zero-padded to 164 bits, and for D = 48, where B is zero-padded to 192 bits.
- R3: After `start` is sampled high with the block not busy, `busy` is high for exactly ceil(163/D) cycles. `done` is then high for one single cycle, in which `busy` is low.
- R4: While `busy` is high, `start` and changes on A and B have no effect on the timing or on the final product.
- R5: While the block is not busy and `start` is low, `product` holds its value from one cycle to the next.
- R6: After reset, `busy` and `done` are low and `product` is zero.
- R7: A `start` sampled during the `done` cycle is accepted, and a new operation begins at once.
- R8: A and B are captured only on the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted when not busy |
| a_in | input | 163 | Multiplicand A |
| b_in | input | 163 | Multiplier B, consumed most significant digit first |
| busy | output | 1 | High while digits are being processed (RUN) |
| done | output | 1 | One-cycle pulse when the product is ready (DONE) |
| product | output | 163 | Accumulator; holds the final product after done |

## Verification
Take the clock edge that accepts `start` as edge k. `busy` is high from just after edge k until edge k+ceil(163/D). `done` and the final `product` then appear just after that edge: edge k+41 for D = 4 and edge k+4 for D = 48. The bench runs both sizes side by side from the same stimulus. It advances a behavioural model at every rising edge and compares `busy`, `done` and the idle-time `product` at the falling edge that follows, so every result is checked in the exact cycle it is due. Expected products come from a full carry-less product that is then reduced from the top, which is a different method from the one the design uses.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } gfm_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/gfm_bitstep.sv
// One MSB-first step: doubling modulo the field polynomial, then a conditional add of A.
module gfm_bitstep #(
    parameter int M = 163,
    parameter logic [M-1:0] TAPS = M'('hC9)
) (
    input  logic [M-1:0] acc_in,
    input  logic [M-1:0] mcand,
    input  logic         bit_in,
    output logic [M-1:0] acc_out
);
    logic         overflow;
    logic [M-1:0] doubled;

    always_comb begin
        overflow = acc_in[M-1];
        doubled  = {acc_in[M-2:0], 1'b0};
        if (overflow) begin
            doubled = doubled ^ TAPS;
        end
        acc_out = bit_in ? (doubled ^ mcand) : doubled;
    end
endmodule

// File: rtl/gfm_digit_chain.sv
// D bit-steps in series; digit bit D-1 is handled first.
module gfm_digit_chain #(
    parameter int M = 163,
    parameter int D = 4,
    parameter logic [M-1:0] TAPS = M'('hC9)
) (
    input  logic [M-1:0] acc_in,
    input  logic [M-1:0] mcand,
    input  logic [D-1:0] digit,
    output logic [M-1:0] acc_out
);
    logic [M-1:0] link [0:D];

    assign link[0] = acc_in;

    for (genvar i = 0; i < D; i++) begin : g_step
        gfm_bitstep #(
            .M    (M),
            .TAPS (TAPS)
        ) u_step (
            .acc_in  (link[i]),
            .mcand   (mcand),
            .bit_in  (digit[D-1-i]),
            .acc_out (link[i+1])
        );
    end

    assign acc_out = link[D];
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
    import gfm_pkg::*;
#(
    parameter int NDIG = 41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (NDIG > 1) ? $clog2(NDIG) : 1;

    gfm_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_digit;

    assign last_digit = (cnt_q == CW'(NDIG - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Digit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step && !last_digit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (last_digit) state_d = S_DONE;
            S_DONE:  state_d = start ? S_RUN : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            S_IDLE: load = start;
            S_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            S_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gfm_msd_mul.sv
module gfm_msd_mul
    import gfm_pkg::*;
#(
    parameter int M = 163,
    parameter int D = 4,
    parameter logic [M-1:0] TAPS = M'('hC9)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] product
);
    localparam int NDIG = ceil_div(M, D);
    localparam int BW   = NDIG * D;

    logic          load, step;
    logic [M-1:0]  acc_q, acc_next, mcand_q;
    logic [BW-1:0] mplier_q;
    logic [D-1:0]  cur_digit;

    gfm_ctrl #(
        .NDIG (NDIG)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    assign cur_digit = mplier_q[BW-1 -: D];

    gfm_digit_chain #(
        .M    (M),
        .D    (D),
        .TAPS (TAPS)
    ) u_chain (
        .acc_in  (acc_q),
        .mcand   (mcand_q),
        .digit   (cur_digit),
        .acc_out (acc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            acc_q    <= '0;
            mcand_q  <= a_in;
            mplier_q <= BW'(b_in);
        end else if (step) begin
            acc_q    <= acc_next;
            mplier_q <= mplier_q << D;
        end
    end

    assign product = acc_q;
endmodule

// File: rtl/gfm_msd_mul_chk.sv
module gfm_msd_mul_chk #(
    parameter int M = 163,
    parameter int D = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] product
);
    localparam int NDIG = (M + D - 1) / D;

    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (!busy) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == NDIG));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R5
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

bind gfm_msd_mul gfm_msd_mul_chk #(
    .M (M),
    .D (D)
) u_gfm_msd_mul_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/gfm_msd_mul_bench.sv
module gfm_msd_mul_bench;
    localparam int M = 163;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [M-1:0] a = '0;
    logic [M-1:0] b = '0;
    logic [1:0] bsy, dn;
    logic [M-1:0] pr [2];

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R6";

    // model state, index 0: D=4, index 1: D=48
    int ndig [2] = '{41, 4};
    logic mbusy [2];
    logic mdone [2];
    int rem [2];
    logic [M-1:0] mprod [2];
    logic [M-1:0] mpend [2];

    always #2 clk = ~clk;

    gfm_msd_mul #(.D(4)) u_gfm_msd_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a), .b_in(b),
        .busy(bsy[0]), .done(dn[0]), .product(pr[0])
    );

    gfm_msd_mul #(.D(48)) u_gfm_msd_mul_d48 (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a), .b_in(b),
        .busy(bsy[1]), .done(dn[1]), .product(pr[1])
    );

    // Reference: carry-less product, then reduction from the top down
    function automatic logic [M-1:0] gf_ref(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [2*M-2:0] full;
        logic [2*M-2:0] poly;
        full = '0;
        for (int i = 0; i < M; i++) begin
            if (y[i]) full = full ^ ((2*M-1)'(x) << i);
        end
        poly = '0;
        poly[M] = 1'b1; poly[7] = 1'b1; poly[6] = 1'b1; poly[3] = 1'b1; poly[0] = 1'b1;
        for (int j = 2*M-2; j >= M; j--) begin
            if (full[j]) full = full ^ (poly << (j - M));
        end
        return full[M-1:0];
    endfunction

    function automatic logic [M-1:0] rnd163();
        logic [191:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return w[M-1:0];
    endfunction

    task automatic check_bit(input string what, input int k, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s inst%0d: got %b expected %b", tag, what, k, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cycles++;
        for (int k = 0; k < 2; k++) begin
            mdone[k] = 1'b0;
            if (!rst_n) begin
                mbusy[k] = 1'b0; mprod[k] = '0;
            end else if (!mbusy[k]) begin
                if (start) begin
                    mbusy[k] = 1'b1; rem[k] = ndig[k];
                    mprod[k] = '0; mpend[k] = gf_ref(a, b);
                end
            end else begin
                rem[k]--;
                if (rem[k] == 0) begin
                    mbusy[k] = 1'b0; mdone[k] = 1'b1; mprod[k] = mpend[k];
                end
            end
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check_bit("R3 busy", k, bsy[k], mbusy[k]);
            check_bit("R3 done", k, dn[k], mdone[k]);
            if (!mbusy[k]) begin
                n_cmp++;
                if (pr[k] !== mprod[k]) begin
                    n_bad++;
                    $display("FAIL %s R1 product inst%0d: got %h expected %h", tag, k, pr[k], mprod[k]);
                end
            end
        end
    endtask

    task automatic mul(input logic [M-1:0] x, input logic [M-1:0] y);
        a = x; b = y; start = 1'b1;
        tick();
        start = 1'b0;
        a = rnd163(); b = rnd163();   // R8: later changes must not matter
        while (mbusy[0] || mbusy[1]) tick();
        tick(); tick();
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            mbusy[k] = 1'b0; mdone[k] = 1'b0; rem[k] = 0; mprod[k] = '0; mpend[k] = '0;
        end
        tag = "R6";
        tick(); tick();
        rst_n = 1'b1;
        tick(); tick();

        tag = "R1-zero";  mul('0, rnd163());
        tag = "R1-zeroB"; mul(rnd163(), '0);
        tag = "R1-one";   mul(M'(1), rnd163());
        tag = "R1-oneB";  mul(rnd163(), M'(1));
        tag = "R1-ones";  mul('1, '1);
        tag = "R2-top";   mul({1'b1, {(M-1){1'b0}}}, {1'b1, {(M-1){1'b0}}});
        tag = "R2";
        for (int n = 0; n < 6; n++) mul(rnd163(), rnd163());

        // R5: idle cycles with changing inputs and no start
        tag = "R5";
        for (int n = 0; n < 5; n++) begin
            a = rnd163(); b = rnd163(); tick();
        end

        // R4 and R7: start held high across busy with operands changing every cycle
        tag = "R4/R7";
        a = rnd163(); b = rnd163(); start = 1'b1;
        for (int n = 0; n < 100; n++) begin
            tick();
            a = rnd163(); b = rnd163();
        end
        start = 1'b0;
        while (mbusy[0] || mbusy[1]) tick();
        tick(); tick();

        // R8: operands changed right after acceptance
        tag = "R8";
        mul(rnd163(), rnd163());

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule